// File: doc/BRIEF.md
# Interrupt Frame Synchronizer

This block runs from the slow clock that keeps a chip alive in its low-power modes. A free-running prescaler produces a periodic frame strobe. The length of the frame is chosen by a 2-bit select. Two interrupt sources are held back until that strobe and then released on it:

- an asynchronous, active-low external interrupt pin;
- a single-cycle overflow pulse from a timer.

The pin is synchronised and then sampled once per frame. A falling edge counts only when the pin was seen high at two successive strobes and then low at two successive strobes. The request therefore appears on the second strobe after the edge. Level periods shorter than a frame on either side of the edge are rejected, and each rejection is reported with a one-cycle missed-edge pulse.

When the low-power flag is dropped, the block is in transition to full-speed operation. Alignment then stops, and both sources pass straight through to their request flags. Each request flag is sticky until it is cleared by a write-one-to-clear pulse. A new event in the same cycle as the clear wins over the clear.

Top module: `frame_int_sync`

## Requirements
- R1: During and after reset, with no stimulus, `extReq`, `tmrReq` and `missedEdge` read 0.
- R2: While `lowPower` is 1, `strobe` is high for one cycle in every frame of 2^BASE_LOG2 cycles (`frameSel`=00), 2^(BASE_LOG2+1) cycles (01), or 2^(BASE_LOG2+2) cycles (10 and 11). The count is taken from a free-running cycle counter cleared by reset. While `lowPower` is 0, `strobe` stays 0.
- R3: `extIntN` passes through a SYNC_STAGES-flop synchroniser. In low power, a falling edge is accepted only if the synchronised level was sampled high at two consecutive strobes and then low at the next two strobes. In that case `extReq` becomes 1 in the cycle after the second low strobe.
- R4: In low power, a high-to-low change between two consecutive strobe samples is rejected if the sample before it was low or the sample after it is high. A rejected change leaves `extReq` unchanged and makes `missedEdge` 1 for exactly one cycle, in the cycle after the deciding strobe.
- R5: In low power, a `timerOvf` pulse is held pending. `tmrReq` becomes 1 only in the cycle after the next strobe, which may be the strobe in the same cycle as the pulse.
- R6: While `lowPower` is 0, requests pass through without alignment:
  - a high-to-low change of the synchronised pin sets `extReq` in the next cycle;
  - a `timerOvf` pulse, or an overflow still pending from low power, sets `tmrReq` in the next cycle.
- R7: A request flag stays 1 until its clear input (`clrExt` or `clrTmr`) is 1 for a cycle. The flag then reads 0 from the next cycle.
- R8: If a request event and the matching clear occur in the same cycle, the flag reads 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow time-base clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowPower | input | 1 | 1 = low-power mode (alignment on), 0 = pass-through |
| frameSel | input | 2 | Frame length select |
| extIntN | input | 1 | Asynchronous active-low external interrupt pin |
| timerOvf | input | 1 | Timer overflow pulse |
| clrExt | input | 1 | Write-one-to-clear for `extReq` |
| clrTmr | input | 1 | Write-one-to-clear for `tmrReq` |
| strobe | output | 1 | Frame strobe, one cycle per frame |
| extReq | output | 1 | Sticky external interrupt request |
| tmrReq | output | 1 | Sticky timer interrupt request |
| missedEdge | output | 1 | One-cycle pulse on a rejected pin edge |

## Verification
The bench builds the block with BASE_LOG2 = 2 and SYNC_STAGES = 2, so the frames are 4, 8 and 16 cycles long.

Short frames bring within a few hundred cycles the following cases:
- all four select codes;
- level periods of exactly one frame on either side of an edge, the shortest that must be rejected;
- overflows that fall on, just after and between strobes.

A long randomized stretch switches between low power and pass-through at arbitrary points in the frame. This exercises pending overflows and pin histories across mode changes.

// File: rtl/fis_pkg.sv
package fis_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic frameTick;  // frame strobe, low-power mode only
    logic passThru;   // alignment bypassed (leaving low power)
  } fisCtl_t;
endpackage

// File: rtl/fis_ctrl.sv
module fis_ctrl
  import fis_pkg::*;
#(
  parameter int BASE_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowPower,
  input  logic [1:0] frameSel,
  output logic       strobe,
  output fisCtl_t    ctl
);
  localparam int CNT_W = BASE_LOG2 + 2;

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] frameMask;
  logic             frameWrap;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    case (frameSel)
      2'b00:   frameMask = {2'b00, {BASE_LOG2{1'b1}}};
      2'b01:   frameMask = {1'b0, {(BASE_LOG2+1){1'b1}}};
      default: frameMask = {CNT_W{1'b1}};
    endcase
  end

  assign frameWrap     = (preCnt & frameMask) == frameMask;
  assign ctl.frameTick = lowPower & frameWrap;
  assign ctl.passThru  = ~lowPower;
  assign strobe        = ctl.frameTick;

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameTick |=> !ctl.frameTick);
  // R2
  no_strobe_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.passThru |-> !strobe);
endmodule

// File: rtl/fis_datapath.sv
module fis_datapath
  import fis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  fisCtl_t ctl,
  input  logic    extIntN,
  input  logic    timerOvf,
  input  logic    clrExt,
  input  logic    clrTmr,
  output logic    extReq,
  output logic    tmrReq,
  output logic    missedEdge
);
  localparam int HIST_W = 3;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinLvl;
  logic                   pinPrev;
  logic [HIST_W-1:0]      hist;   // hist[0] newest strobe sample
  logic                   tmrPend;
  logic                   fallSeen, extAccept, extMiss, extPass;
  logic                   extEvt, tmrEvt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= extIntN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extIntN};
      end
    end
  endgenerate

  assign pinLvl = syncQ[SYNC_STAGES-1];

  // Edge qualification from the strobe-sampled history
  assign fallSeen  = hist[1] & ~hist[0];
  assign extAccept = ctl.frameTick & fallSeen & hist[2] & ~pinLvl;
  assign extMiss   = ctl.frameTick & fallSeen & ~(hist[2] & ~pinLvl);
  assign extPass   = ctl.passThru & pinPrev & ~pinLvl;
  assign extEvt    = extAccept | extPass;
  assign tmrEvt    = (tmrPend | timerOvf) & (ctl.frameTick | ctl.passThru);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev    <= 1'b1;
      hist       <= '1;
      tmrPend    <= 1'b0;
      extReq     <= 1'b0;
      tmrReq     <= 1'b0;
      missedEdge <= 1'b0;
    end else begin
      pinPrev <= pinLvl;
      if (ctl.passThru)       hist <= {HIST_W{pinLvl}};
      else if (ctl.frameTick) hist <= {hist[HIST_W-2:0], pinLvl};

      if (tmrEvt)        tmrPend <= 1'b0;
      else if (timerOvf) tmrPend <= 1'b1;

      if (extEvt)      extReq <= 1'b1;
      else if (clrExt) extReq <= 1'b0;

      if (tmrEvt)      tmrReq <= 1'b1;
      else if (clrTmr) tmrReq <= 1'b0;

      missedEdge <= extMiss;
    end
  end

  // R3
  ext_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extReq) |-> $past(ctl.frameTick | ctl.passThru));
  // R5
  tmr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmrReq) |-> $past(ctl.frameTick | ctl.passThru));
  // R4
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    missedEdge |-> !$rose(extReq));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.passThru && timerOvf && clrTmr) |=> tmrReq);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrExt && !ctl.frameTick && !ctl.passThru) |=> !extReq);
endmodule

// File: rtl/frame_int_sync.sv
module frame_int_sync
  import fis_pkg::*;
#(
  parameter int BASE_LOG2   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowPower,
  input  logic [1:0] frameSel,
  input  logic       extIntN,
  input  logic       timerOvf,
  input  logic       clrExt,
  input  logic       clrTmr,
  output logic       strobe,
  output logic       extReq,
  output logic       tmrReq,
  output logic       missedEdge
);
  fisCtl_t ctl;

  fis_ctrl #(.BASE_LOG2(BASE_LOG2)) uCtrl (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .frameSel(frameSel),
    .strobe(strobe), .ctl(ctl)
  );

  fis_datapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .extIntN(extIntN),
    .timerOvf(timerOvf), .clrExt(clrExt), .clrTmr(clrTmr),
    .extReq(extReq), .tmrReq(tmrReq), .missedEdge(missedEdge)
  );
endmodule

// File: tb/tb_frame_int_sync.sv
module tb_frame_int_sync;
  localparam int CLK_P = 10;
  localparam int B     = 2;

  logic clk = 0;
  logic rstN = 0;
  logic lowPower = 1;
  logic [1:0] frameSel = 0;
  logic extIntN = 1, timerOvf = 0, clrExt = 0, clrTmr = 0;
  logic strobe, extReq, tmrReq, missedEdge;

  int nChk = 0, nFail = 0, missCnt = 0;

  frame_int_sync #(.BASE_LOG2(B), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .lowPower(lowPower), .frameSel(frameSel),
    .extIntN(extIntN), .timerOvf(timerOvf), .clrExt(clrExt), .clrTmr(clrTmr),
    .strobe(strobe), .extReq(extReq), .tmrReq(tmrReq), .missedEdge(missedEdge)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int frameLen(input logic [1:0] s);
    if (s == 2'b00) return 1 << B;
    if (s == 2'b01) return 1 << (B + 1);
    return 1 << (B + 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  mCnt;
  bit  sA, sB, prevL, pend, eReq, tReq, miss;
  bit  smp[$];

  always @(posedge clk) begin
    int  L;
    bit  tk, lv, eEv, mEv, tEv;
    if (!rstN) begin
      mCnt = 0; sA = 1; sB = 1; prevL = 1; pend = 0;
      eReq = 0; tReq = 0; miss = 0; smp = '{1, 1, 1};
    end else begin
      L  = frameLen(frameSel);
      tk = lowPower && (mCnt % L == L - 1);
      lv = sB; eEv = 0; mEv = 0;
      if (!lowPower) begin
        eEv = prevL && !lv;
        smp = '{lv, lv, lv};
      end else if (tk) begin
        if (smp[1] && !smp[2]) begin
          if (smp[0] && !lv) eEv = 1; else mEv = 1;
        end
        smp.push_back(lv);
        void'(smp.pop_front());
      end
      tEv  = (pend || timerOvf) && (tk || !lowPower);
      pend = tEv ? 0 : (pend || timerOvf);
      eReq = eEv ? 1 : (clrExt ? 0 : eReq);
      tReq = tEv ? 1 : (clrTmr ? 0 : tReq);
      miss = mEv;
      prevL = lv; sB = sA; sA = extIntN;
      mCnt++;
    end
  end

  // Per-cycle comparison, away from the edge
  always @(posedge clk) begin
    int L;
    #1;
    if (rstN) begin
      L = frameLen(frameSel);
      chk(strobe == (lowPower && (mCnt % L == L - 1)), "R2 strobe", strobe,
          int'(lowPower && (mCnt % L == L - 1)));
      chk(extReq == eReq, "R3/R4/R6 extReq", extReq, eReq);
      chk(tmrReq == tReq, "R5/R6 tmrReq", tmrReq, tReq);
      chk(missedEdge == miss, "R4 missedEdge", missedEdge, miss);
      if (missedEdge) missCnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!strobe);
  endtask

  task automatic pulseClr();
    clrExt = 1; clrTmr = 1; cyc(1); clrExt = 0; clrTmr = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int n, L;
    cyc(3);
    // R1 reset state
    chk(!extReq && !tmrReq && !missedEdge, "R1 reset outputs", {extReq, tmrReq, missedEdge}, 0);
    rstN = 1;
    cyc(2);
    chk(!extReq && !tmrReq && !missedEdge, "R1 idle after reset", {extReq, tmrReq, missedEdge}, 0);

    // R2 frame lengths for every select code
    for (int s = 0; s < 4; s++) begin
      frameSel = 2'(s);
      waitStrobe();
      n = 0;
      do begin @(negedge clk); n++; end while (!strobe);
      chk(n == frameLen(2'(s)), "R2 frame length", n, frameLen(2'(s)));
    end
    frameSel = 0; L = frameLen(0);

    // R4 low too short
    cyc(4 * L); missCnt = 0;
    extIntN = 0; cyc(L); extIntN = 1; cyc(4 * L);
    chk(extReq == 0, "R4 short low no request", extReq, 0);
    chk(missCnt == 1, "R4 short low missed", missCnt, 1);

    // R3 long edge accepted
    extIntN = 0; cyc(5 * L);
    chk(extReq == 1, "R3 long edge accepted", extReq, 1);
    // R7 clear
    pulseClr(); cyc(1);
    chk(extReq == 0, "R7 clear extReq", extReq, 0);

    // R4 high too short before edge
    missCnt = 0;
    extIntN = 1; cyc(L); extIntN = 0; cyc(5 * L);
    chk(extReq == 0, "R4 short high no request", extReq, 0);
    chk(missCnt == 1, "R4 short high missed", missCnt, 1);
    extIntN = 1; cyc(3 * L);

    // R5 overflow waits for strobe
    waitStrobe(); cyc(1);
    timerOvf = 1; cyc(1); timerOvf = 0;
    chk(tmrReq == 0, "R5 held before strobe", tmrReq, 0);
    waitStrobe(); cyc(1);
    chk(tmrReq == 1, "R5 set after strobe", tmrReq, 1);
    pulseClr(); cyc(1);
    chk(tmrReq == 0, "R7 clear tmrReq", tmrReq, 0);

    // R6 pending overflow released on leaving low power
    waitStrobe(); cyc(1);
    timerOvf = 1; cyc(1); timerOvf = 0; lowPower = 0; cyc(1);
    chk(tmrReq == 1, "R6 pending passes through", tmrReq, 1);
    pulseClr();
    // R6 pin edge in pass-through
    extIntN = 0; cyc(4);
    chk(extReq == 1, "R6 pin edge pass-through", extReq, 1);
    // R8 event beats clear
    timerOvf = 1; clrTmr = 1; cyc(1); timerOvf = 0; clrTmr = 0;
    chk(tmrReq == 1, "R8 set beats clear", tmrReq, 1);
    pulseClr(); extIntN = 1; cyc(3); lowPower = 1;

    // Randomized mix checked by the model every cycle
    for (int i = 0; i < 400; i++) begin
      extIntN  = $urandom_range(0, 1);
      timerOvf = ($urandom_range(0, 5) == 0);
      clrExt   = ($urandom_range(0, 7) == 0);
      clrTmr   = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) lowPower = ~lowPower;
      if ($urandom_range(0, 31) == 0) frameSel = 2'($urandom_range(0, 3));
      cyc(1);
      timerOvf = 0; clrExt = 0; clrTmr = 0;
      cyc($urandom_range(0, 3 * frameLen(frameSel)));
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule